// File: doc/BRIEF.md
# Fetch-Stage Direction and Target Predictor

This block guesses, in the same cycle as an instruction fetch, whether the fetched address holds a branch that will be taken and where fetch should go next. It keeps two structures. The first is a table of two-bit hysteresis counters selected by low address bits. The second is a small direct-mapped target store that remembers the address and destination of branches that were recently taken. A redirect happens only when the fetch address matches a valid target entry and its counter leans toward taken. In every other case fetch continues with the next sequential word.

The execute stage reports each resolved branch through an update port: its address, whether it was taken, and where it went. Every report moves the branch's counter one step, saturating at both ends. A taken report also installs the address and target in the target store. Because both structures are registered, a report takes effect from the clock edge that samples it. A lookup in that same cycle still sees the old contents.

Top module: `branch_predictor`

## Requirements
- R1: After reset every counter holds weakly-not-taken (01) and every target entry is invalid, so any lookup returns not taken with next address equal to the fetch address plus 4.
- R2: Whenever the lookup does not predict taken, the next address is the fetch address plus 4.
- R3: A taken report moves the selected counter up one state (00 to 01 to 10 to 11) and holds it at 11 once it is there.
- R4: A not-taken report moves the selected counter down one state and holds it at 00 once it is there.
- R5: From strongly taken (11), one not-taken report leaves the prediction taken, and a second consecutive one turns it to not taken.
- R6: A taken report writes the valid bit, the address tag and the target into the selected target entry. A not-taken report leaves the target store unchanged while still moving the counter.
- R7: The lookup predicts taken exactly when the selected target entry is valid, its tag equals the fetch address tag, and the counter's high bit is 1. The next address is then the stored target.
- R8: A fetch address whose tag differs from the stored tag at the same entry is not redirected, even when the counter says taken. A taken report for such an address replaces the earlier entry.
- R9: A lookup made in the same cycle as a report to the same entries returns the values from before that report.
- R10: With default sizes, address bits [7:2] select the counter, bits [5:2] select the target entry, and bits [31:6] form the tag. Addresses that differ in bits [5:2] use separate entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| lu_pc | input | PC_W | Fetch address being looked up |
| lu_taken | output | 1 | Predicted taken with a known target |
| lu_next_pc | output | PC_W | Predicted next fetch address |
| up_valid | input | 1 | A resolved branch report is present this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 for taken |
| up_target | input | PC_W | Actual destination of the branch |

## Verification
Lookups are purely combinational from the stored state, so the bench applies a fetch address after a falling edge and reads `lu_taken` and `lu_next_pc` a short delay later, with no clock edge in between. A report becomes visible one rising edge after it is driven. The bench holds each report across exactly one rising edge, drops it on the next falling edge, and only then looks up. In the same-cycle case it samples once before that edge, expecting the old answer, and once after, expecting the new one.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        CNT_STRONG_NT = 2'b00,
        CNT_WEAK_NT   = 2'b01,
        CNT_WEAK_T    = 2'b10,
        CNT_STRONG_T  = 2'b11
    } cnt_state_e;

    localparam cnt_state_e CNT_RESET = CNT_WEAK_NT;

    function automatic cnt_state_e cnt_step(cnt_state_e cur, logic taken);
        cnt_state_e nxt;
        nxt = cur;
        case (cur)
            CNT_STRONG_NT: nxt = taken ? CNT_WEAK_NT  : CNT_STRONG_NT;
            CNT_WEAK_NT:   nxt = taken ? CNT_WEAK_T   : CNT_STRONG_NT;
            CNT_WEAK_T:    nxt = taken ? CNT_STRONG_T : CNT_WEAK_NT;
            CNT_STRONG_T:  nxt = taken ? CNT_STRONG_T : CNT_WEAK_T;
            default:       nxt = CNT_RESET;
        endcase
        return nxt;
    endfunction

    function automatic logic cnt_says_taken(cnt_state_e s);
        return s[1];
    endfunction

endpackage

// File: rtl/bp_counter_table.sv
module bp_counter_table
    import bp_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output cnt_state_e       rd_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    cnt_state_e state_arr [ENTRIES];

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_cnt
            cnt_state_e q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= CNT_RESET;
                end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                    q <= cnt_step(q, wr_taken);
                end
            end
            assign state_arr[i] = q;
        end
    endgenerate

    assign rd_state = state_arr[rd_idx];

endmodule

// File: rtl/bp_target_buffer.sv
module bp_target_buffer #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 26,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target
);

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  target;
    } entry_t;

    entry_t entry_arr [ENTRIES];
    entry_t sel;

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
            entry_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                    q.valid  <= 1'b1;
                    q.tag    <= wr_tag;
                    q.target <= wr_target;
                end
            end
            assign entry_arr[i] = q;
        end
    endgenerate

    always_comb begin
        sel       = entry_arr[rd_idx];
        rd_hit    = sel.valid && (sel.tag == rd_tag);
        rd_target = sel.target;
    end

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor
    import bp_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int CNT_ENTRIES = 64,
    parameter int BTB_ENTRIES = 16,
    parameter int INSTR_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lu_pc,
    output logic            lu_taken,
    output logic [PC_W-1:0] lu_next_pc,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic [PC_W-1:0] up_target
);

    localparam int OFF_W  = $clog2(INSTR_BYTES);
    localparam int CIDX_W = $clog2(CNT_ENTRIES);
    localparam int BIDX_W = $clog2(BTB_ENTRIES);
    localparam int TAG_W  = PC_W - OFF_W - BIDX_W;

    logic [CIDX_W-1:0] lu_cidx, up_cidx;
    logic [BIDX_W-1:0] lu_bidx, up_bidx;
    logic [TAG_W-1:0]  lu_tag, up_tag;
    cnt_state_e        lu_state;
    logic              btb_hit;
    logic [PC_W-1:0]   btb_target;
    logic [PC_W-1:0]   seq_pc;
    logic              unused_up_low;

    assign lu_cidx = lu_pc[OFF_W +: CIDX_W];
    assign up_cidx = up_pc[OFF_W +: CIDX_W];
    assign lu_bidx = lu_pc[OFF_W +: BIDX_W];
    assign up_bidx = up_pc[OFF_W +: BIDX_W];
    assign lu_tag  = lu_pc[PC_W-1 -: TAG_W];
    assign up_tag  = up_pc[PC_W-1 -: TAG_W];
    assign unused_up_low = ^up_pc[OFF_W-1:0];

    bp_counter_table #(
        .ENTRIES (CNT_ENTRIES)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lu_cidx),
        .rd_state (lu_state),
        .wr_en    (up_valid),
        .wr_idx   (up_cidx),
        .wr_taken (up_taken)
    );

    bp_target_buffer #(
        .PC_W    (PC_W),
        .ENTRIES (BTB_ENTRIES),
        .TAG_W   (TAG_W)
    ) u_btb (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (lu_bidx),
        .rd_tag    (lu_tag),
        .rd_hit    (btb_hit),
        .rd_target (btb_target),
        .wr_en     (up_valid && up_taken),
        .wr_idx    (up_bidx),
        .wr_tag    (up_tag),
        .wr_target (up_target)
    );

    always_comb begin
        seq_pc     = lu_pc + PC_W'(INSTR_BYTES);
        lu_taken   = btb_hit && cnt_says_taken(lu_state);
        lu_next_pc = lu_taken ? btb_target : seq_pc;
    end

endmodule

// File: rtl/branch_predictor_chk.sv
module branch_predictor_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] lu_pc,
    input logic            lu_taken,
    input logic [PC_W-1:0] lu_next_pc,
    input logic            up_valid,
    input logic            up_taken,
    input logic            btb_hit
);

    logic seen_taken;

    always_ff @(posedge clk) begin
        if (rst) seen_taken <= 1'b0;
        else if (up_valid && up_taken) seen_taken <= 1'b1;
    end

    // R1: leaving reset, nothing can redirect
    a_r1_reset_no_redirect: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !lu_taken);

    // R2: fall-through goes to the next word
    a_r2_fallthrough: assert property (@(posedge clk) disable iff (rst)
        !lu_taken |-> (lu_next_pc == lu_pc + PC_W'(4)));

    // R6: only a taken report can create a redirect
    a_r6_no_redirect_untrained: assert property (@(posedge clk) disable iff (rst)
        !seen_taken |-> !lu_taken);

    // R7: a redirect needs a hit in the target store
    a_r7_taken_needs_hit: assert property (@(posedge clk) disable iff (rst)
        lu_taken |-> btb_hit);

    // R9: without a report the answer for a held address does not change
    a_r9_state_holds: assert property (@(posedge clk) disable iff (rst)
        (!up_valid ##1 $stable(lu_pc)) |-> $stable(lu_taken) && $stable(lu_next_pc));

endmodule

bind branch_predictor branch_predictor_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lu_pc      (lu_pc),
    .lu_taken   (lu_taken),
    .lu_next_pc (lu_next_pc),
    .up_valid   (up_valid),
    .up_taken   (up_taken),
    .btb_hit    (btb_hit)
);

// File: tb/branch_predictor_tb.sv
`timescale 1ns/1ps
module branch_predictor_tb;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] lu_pc = '0;
    logic            lu_taken;
    logic [PC_W-1:0] lu_next_pc;
    logic            up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic            up_taken = 1'b0;
    logic [PC_W-1:0] up_target = '0;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    branch_predictor u_dut (
        .clk        (clk),
        .rst        (rst),
        .lu_pc      (lu_pc),
        .lu_taken   (lu_taken),
        .lu_next_pc (lu_next_pc),
        .up_valid   (up_valid),
        .up_pc      (up_pc),
        .up_taken   (up_taken),
        .up_target  (up_target)
    );

    localparam logic [31:0] PA = 32'h1000_0040;
    localparam logic [31:0] TA = 32'h2000_0100;
    localparam logic [31:0] PC_ALIAS = 32'h3000_0040;
    localparam logic [31:0] TC = 32'h4000_0000;
    localparam logic [31:0] PD = 32'h1000_0044;
    localparam logic [31:0] PE = 32'h0000_0204;
    localparam logic [31:0] TE = 32'h0000_8000;

    task automatic look(input logic [31:0] pc, input logic exp_t,
                        input logic [31:0] exp_n, input string req);
        lu_pc = pc;
        #1;
        n_run++;
        if (lu_taken !== exp_t || lu_next_pc !== exp_n) begin
            n_fail++;
            $display("FAIL %s pc=%h: taken=%b next=%h expected taken=%b next=%h",
                     req, pc, lu_taken, lu_next_pc, exp_t, exp_n);
        end
    endtask

    task automatic report(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_taken = tk; up_target = tgt;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic t_reset;
        look(PA, 1'b0, PA + 4, "R1");
        look(32'hFFFF_FFFC, 1'b0, 32'h0000_0000, "R1");
        look(PE, 1'b0, PE + 4, "R2");
    endtask

    task automatic t_train;
        report(PA, 1'b1, TA);                 // 01 -> 10, entry written
        look(PA, 1'b1, TA, "R7");
        look(PD, 1'b0, PD + 4, "R10");        // neighbour entry untouched
    endtask

    task automatic t_hysteresis;
        report(PA, 1'b1, TA);                 // 11
        report(PA, 1'b1, TA);                 // stays 11
        report(PA, 1'b0, TA);                 // 10
        look(PA, 1'b1, TA, "R5");
        report(PA, 1'b0, TA);                 // 01
        look(PA, 1'b0, PA + 4, "R5");
    endtask

    task automatic t_floor;
        report(PA, 1'b0, TA);                 // 00
        report(PA, 1'b0, TA);                 // stays 00
        report(PA, 1'b1, TA);                 // 01
        look(PA, 1'b0, PA + 4, "R4");
        report(PA, 1'b1, TA);                 // 10, entry still valid
        look(PA, 1'b1, TA, "R6");
    endtask

    task automatic t_ceiling;
        report(PA, 1'b1, TA);                 // 11
        report(PA, 1'b1, TA);                 // stays 11
        report(PA, 1'b1, TA);                 // stays 11
        report(PA, 1'b0, TA);                 // 10
        look(PA, 1'b1, TA, "R3");
        report(PA, 1'b0, TA);                 // 01
        look(PA, 1'b0, PA + 4, "R3");
        report(PA, 1'b1, TA);                 // 10
    endtask

    task automatic t_alias;
        look(PC_ALIAS, 1'b0, PC_ALIAS + 4, "R8");
        report(PC_ALIAS, 1'b1, TC);           // shared counter 11, entry replaced
        look(PC_ALIAS, 1'b1, TC, "R8");
        look(PA, 1'b0, PA + 4, "R8");
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        up_valid = 1'b1; up_pc = PE; up_taken = 1'b1; up_target = TE;
        look(PE, 1'b0, PE + 4, "R9");
        @(negedge clk);
        up_valid = 1'b0;
        look(PE, 1'b1, TE, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_train();
        t_hysteresis();
        t_floor();
        t_ceiling();
        t_alias();
        t_same_cycle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule